// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Word

This block is a purely combinational integer unit for an 8/16-bit processor datapath. It takes two 16-bit operands, a 3-bit operation code and a width select, and returns a 16-bit result together with a 16-bit status word. The status word carries the six arithmetic condition bits at fixed positions, copies three control bits from an input unchanged, and holds zero in every other bit.

The width select chooses between byte operation (low 8 bits only) and word operation (all 16 bits). Carry, zero, sign, overflow and auxiliary carry are computed at the selected width. Parity always covers the low byte of the result. One of the add variants sign-extends the low byte of the second operand to a word before adding, which is how a displacement or a short immediate is applied to a 16-bit value. Subtraction serves both for arithmetic and for compare, where the caller keeps the status word and discards the result.

Top module: `bw_alu`

## Requirements
- R1: Opcode 0 (add) returns (a_in + b_in) at the active width, and status bit 0 (carry) is the carry out of bit 7 (wide_in=0) or bit 15 (wide_in=1).
- R2: Opcode 1 (add with extended byte) with wide_in=1 adds a_in to the value of b_in[7:0] sign-extended to 16 bits, ignoring b_in[15:8]; with wide_in=0 it behaves as opcode 0. Carry follows R1.
- R3: Opcode 2 (subtract/compare) returns (a_in - b_in) at the active width, and status bit 0 is set when a borrow into the top bit occurs (unsigned a < b at that width).
- R4: Opcodes 3, 4 and 5 return the bitwise AND, OR and XOR at the active width, and clear status bits 0 (carry), 4 (auxiliary) and 11 (overflow).
- R5: For opcodes 0 to 5, status bit 6 is set when the result at the active width is zero, and status bit 7 equals result bit 7 (byte) or bit 15 (word).
- R6: For opcodes 0 to 5, status bit 2 is set when result bits [7:0] hold an even number of ones, whatever the width.
- R7: For opcodes 0 to 2, status bit 4 holds the carry out of bit 3 (add) or the borrow into bit 4 (subtract).
- R8: For opcodes 0 to 2, status bit 11 is set when the two's-complement result at the active width overflows.
- R9: With wide_in=0, res_out[15:8] is zero for every opcode.
- R10: Opcodes 6 and 7 return a zero result with status bits 0, 2, 4, 6, 7 and 11 all clear.
- R11: Status bits 8, 9 and 10 equal ctrl_in[0], ctrl_in[1] and ctrl_in[2] for every opcode; status bits 1, 3, 5 and 15:12 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| op_in | input | 3 | Operation code: 0 add, 1 add with sign-extended byte, 2 subtract, 3 AND, 4 OR, 5 XOR |
| wide_in | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| ctrl_in | input | 3 | Control bits copied to status bits 8, 9, 10 |
| res_out | output | 16 | Result |
| stat_out | output | 16 | Status word |

## Verification
Byte mode is swept over every operand pair for each opcode, so the carry and borrow at the 0x7F/0x80 and 0xFF/0x00 boundaries, the nibble carry at 0x0F, and parity on all 256 result values are all covered; a design that took carry from bit 16 in byte mode, or parity from the full word, fails there at once. Word mode runs a grid of boundary values (0, 1, 0x7FFF, 0x8000, 0xFFFF, 0x00FF, 0x0100 and neighbours) plus pseudo-random pairs, which catches an overflow rule using the byte sign bit or a sign extension that takes bit 15 instead of bit 7. Undefined opcodes and all control-bit patterns are run so that a leaking result, stale flags or a dropped control bit shows at the ports.

// File: rtl/bw_alu_pkg.sv
// Shared definitions for the byte/word ALU: operation codes and the fixed
// bit positions of the status word.
package bw_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDSX = 3'd1,
        OP_SUB   = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5
    } alu_op_e;

    // Status word bit positions; consumers decode these, so they are fixed.
    localparam int ST_CARRY = 0;
    localparam int ST_PAR   = 2;
    localparam int ST_AUX   = 4;
    localparam int ST_ZERO  = 6;
    localparam int ST_SIGN  = 7;
    localparam int ST_CTL0  = 8;
    localparam int ST_OVF   = 11;
    localparam int CTL_W    = 3;
    localparam int STAT_W   = 16;

    // Flags that only the adder/subtractor produces.
    typedef struct packed {
        logic carry;
        logic aux;
        logic ovf;
    } arith_flags_t;

endpackage

// File: rtl/bw_alu_operand.sv
// Operand preparation. Masks both operands to the active width and, for the
// extended-byte add in word mode, sign-extends the low byte of B.
// Assumes DATA_W is even; the low half is the byte lane.
module bw_alu_operand
    import bw_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_raw,
    input  logic [DATA_W-1:0] b_raw,
    input  logic [2:0]        op,
    input  logic              wide,
    output logic [DATA_W-1:0] a_w,
    output logic [DATA_W-1:0] b_w
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_src;

    // Choose plain B or B's low byte extended by its sign bit.
    always_comb begin
        if (op == OP_ADDSX) begin
            b_src = {{HALF_W{b_raw[HALF_W-1]}}, b_raw[HALF_W-1:0]};
        end else begin
            b_src = b_raw;
        end
    end

    // Clear the upper half of both operands in byte mode.
    always_comb begin
        if (wide) begin
            a_w = a_raw;
            b_w = b_src;
        end else begin
            a_w = {{HALF_W{1'b0}}, a_raw[HALF_W-1:0]};
            b_w = {{HALF_W{1'b0}}, b_src[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/bw_alu_arith.sv
// Adder/subtractor with carry, auxiliary carry and overflow at the active
// width. Assumes operands arrive already masked to that width, so one
// DATA_W+1 bit operation serves both widths.
module bw_alu_arith
    import bw_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_w,
    input  logic [DATA_W-1:0] b_w,
    input  logic              subtract,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output arith_flags_t      flags
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EXT_W  = DATA_W + 1;
    localparam int NIB    = 4;

    logic [EXT_W-1:0] raw;
    logic             a_top, b_top, r_top;

    // One extended add or subtract; the extra bit captures carry or borrow.
    always_comb begin
        if (subtract) begin
            raw = {1'b0, a_w} - {1'b0, b_w};
        end else begin
            raw = {1'b0, a_w} + {1'b0, b_w};
        end
    end

    // Trim the result and pick the top bits of the active width.
    always_comb begin
        if (wide) begin
            sum   = raw[DATA_W-1:0];
            a_top = a_w[DATA_W-1];
            b_top = b_w[DATA_W-1];
            r_top = raw[DATA_W-1];
        end else begin
            sum   = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
            a_top = a_w[HALF_W-1];
            b_top = b_w[HALF_W-1];
            r_top = raw[HALF_W-1];
        end
    end

    // Carry/borrow at the width boundary, nibble carry and signed overflow.
    always_comb begin
        flags.carry = wide ? raw[DATA_W] : raw[HALF_W];
        flags.aux   = a_w[NIB] ^ b_w[NIB] ^ raw[NIB];
        if (subtract) begin
            flags.ovf = (a_top != b_top) && (r_top != a_top);
        end else begin
            flags.ovf = (a_top == b_top) && (r_top != a_top);
        end
    end

endmodule

// File: rtl/bw_alu_logic.sv
// Bitwise unit for AND, OR and XOR. Any other code yields zero.
// Assumes operands are already masked to the active width.
module bw_alu_logic
    import bw_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_w,
    input  logic [DATA_W-1:0] b_w,
    input  logic [2:0]        op,
    output logic [DATA_W-1:0] res
);
    // Select the bitwise function.
    always_comb begin
        unique case (op)
            OP_AND:  res = a_w & b_w;
            OP_OR:   res = a_w | b_w;
            OP_XOR:  res = a_w ^ b_w;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/bw_alu_flags.sv
// Status word assembly. Derives zero, sign and parity from the final result,
// merges the adder flags, and copies the control bits through. Assumes a
// 16-bit status layout and a result already zeroed above the active width.
module bw_alu_flags
    import bw_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    input  logic              defined,
    input  logic              use_arith,
    input  arith_flags_t      aflags,
    input  logic [CTL_W-1:0]  ctrl,
    output logic [STAT_W-1:0] status
);
    localparam int HALF_W = DATA_W / 2;

    logic zero_f, sign_f, par_f;

    // Result-derived flags at the active width; parity on the low byte.
    always_comb begin
        zero_f = wide ? (res == '0) : (res[HALF_W-1:0] == '0);
        sign_f = wide ? res[DATA_W-1] : res[HALF_W-1];
        par_f  = ~^res[HALF_W-1:0];
    end

    // Place each flag at its fixed position; control bits via a loop.
    always_comb begin
        status = '0;
        status[ST_CARRY] = use_arith & aflags.carry;
        status[ST_AUX]   = use_arith & aflags.aux;
        status[ST_OVF]   = use_arith & aflags.ovf;
        status[ST_ZERO]  = defined & zero_f;
        status[ST_SIGN]  = defined & sign_f;
        status[ST_PAR]   = defined & par_f;
        for (int i = 0; i < CTL_W; i++) begin
            status[ST_CTL0+i] = ctrl[i];
        end
    end

endmodule

// File: rtl/bw_alu.sv
// Byte/word ALU top. Combinational: operands in, result and status word out.
// Assumes DATA_W = 16 so the status layout in the package applies.
module bw_alu
    import bw_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [2:0]        op_in,
    input  logic              wide_in,
    input  logic [CTL_W-1:0]  ctrl_in,
    output logic [DATA_W-1:0] res_out,
    output logic [STAT_W-1:0] stat_out
);
    logic [DATA_W-1:0] a_w, b_w, sum, lres;
    arith_flags_t      aflags;
    logic              is_arith, is_logic, is_sub;

    // Classify the operation code.
    always_comb begin
        is_arith = (op_in == OP_ADD) || (op_in == OP_ADDSX) || (op_in == OP_SUB);
        is_logic = (op_in == OP_AND) || (op_in == OP_OR) || (op_in == OP_XOR);
        is_sub   = (op_in == OP_SUB);
    end

    bw_alu_operand #(.DATA_W(DATA_W)) u_opnd (
        .a_raw (a_in),
        .b_raw (b_in),
        .op    (op_in),
        .wide  (wide_in),
        .a_w   (a_w),
        .b_w   (b_w)
    );

    bw_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a_w      (a_w),
        .b_w      (b_w),
        .subtract (is_sub),
        .wide     (wide_in),
        .sum      (sum),
        .flags    (aflags)
    );

    bw_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_w (a_w),
        .b_w (b_w),
        .op  (op_in),
        .res (lres)
    );

    // Pick the result source; undefined codes give zero.
    always_comb begin
        if (is_arith) begin
            res_out = sum;
        end else if (is_logic) begin
            res_out = lres;
        end else begin
            res_out = '0;
        end
    end

    bw_alu_flags #(.DATA_W(DATA_W)) u_flags (
        .res       (res_out),
        .wide      (wide_in),
        .defined   (is_arith | is_logic),
        .use_arith (is_arith),
        .aflags    (aflags),
        .ctrl      (ctrl_in),
        .status    (stat_out)
    );

endmodule

// File: rtl/bw_alu_chk.sv
// Checker for the byte/word ALU, bound to every bw_alu instance. The block is
// combinational, so the checks are immediate assertions on settled ports.
module bw_alu_chk (
    input logic [15:0] a_in,
    input logic [15:0] b_in,
    input logic [2:0]  op_in,
    input logic        wide_in,
    input logic [2:0]  ctrl_in,
    input logic [15:0] res_out,
    input logic [15:0] stat_out
);
    logic known;

    // Only judge ports once inputs carry real values.
    always_comb begin
        known = !$isunknown({a_in, b_in, op_in, wide_in, ctrl_in});
    end

    // Port-level relations that hold for every input combination.
    always_comb begin
        if (known) begin
            // R9
            upper_clear_chk: assert (wide_in || res_out[15:8] == 8'h00)
                else $error("byte mode left upper result bits set");
            // R11
            ctrl_pass_chk: assert (stat_out[10:8] == ctrl_in)
                else $error("control bits not copied to status");
            // R11
            reserved_zero_chk: assert (stat_out[15:12] == 4'h0 && stat_out[5] == 1'b0
                                       && stat_out[3] == 1'b0 && stat_out[1] == 1'b0)
                else $error("reserved status bit set");
            // R10
            undef_quiet_chk: assert (op_in < 3'd6 || (res_out == 16'h0
                                     && (stat_out & 16'h08D5) == 16'h0))
                else $error("undefined opcode produced output");
            // R4
            logic_flags_chk: assert (op_in < 3'd3 || op_in > 3'd5
                                     || (stat_out & 16'h0811) == 16'h0)
                else $error("logic op left carry/aux/overflow set");
            // R5
            zero_flag_chk: assert (op_in > 3'd5 || stat_out[6] ==
                                   (wide_in ? (res_out == 16'h0) : (res_out[7:0] == 8'h0)))
                else $error("zero flag disagrees with result");
        end
    end

endmodule

bind bw_alu bw_alu_chk u_chk (
    .a_in     (a_in),
    .b_in     (b_in),
    .op_in    (op_in),
    .wide_in  (wide_in),
    .ctrl_in  (ctrl_in),
    .res_out  (res_out),
    .stat_out (stat_out)
);

// File: tb/bw_alu_test.sv
// Self-checking bench: exhaustive byte-mode sweep, word-mode boundary grid
// and pseudo-random pairs, undefined codes and control pass-through.
module bw_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [2:0]  op_in = '0;
    logic        wide_in = 1'b0;
    logic [2:0]  ctrl_in = '0;
    logic [15:0] res_out, stat_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bw_alu uut (
        .a_in     (a_in),
        .b_in     (b_in),
        .op_in    (op_in),
        .wide_in  (wide_in),
        .ctrl_in  (ctrl_in),
        .res_out  (res_out),
        .stat_out (stat_out)
    );

    // Watchdog: counts cycles after reset; expiry is a failed check.
    always @(posedge clk) begin
        if (rst_n && !done) begin
            cycles <= cycles + 1;
            if (cycles == 150000) begin
                failures = failures + 1;
                checks = checks + 1;
                $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    // Reference model written from the requirements with integer arithmetic.
    task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                         input logic w, input logic [2:0] ctl,
                         output logic [15:0] r, output logic [15:0] st);
        int mask, half, ai, bi, sa, sb, sr, t, ones, top;
        logic c, af, ov, defd;
        mask = w ? 65535 : 255;
        half = (mask + 1) / 2;
        top  = w ? 15 : 7;
        ai = int'(a) & mask;
        if (op == 3'd1) bi = w ? ((b[7] ? 32'hFF00 : 0) | int'(b[7:0])) : int'(b[7:0]);
        else            bi = int'(b) & mask;
        sa = (ai >= half) ? ai - (mask + 1) : ai;
        sb = (bi >= half) ? bi - (mask + 1) : bi;
        c = 0; af = 0; ov = 0; defd = 1; t = 0;
        case (op)
            3'd0, 3'd1: begin
                t = ai + bi; c = (t > mask); af = ((ai & 15) + (bi & 15)) > 15;
                sr = sa + sb; ov = (sr >= half) || (sr < -half);
            end
            3'd2: begin
                t = ai - bi; c = (ai < bi); af = (ai & 15) < (bi & 15);
                sr = sa - sb; ov = (sr >= half) || (sr < -half);
            end
            3'd3: t = ai & bi;
            3'd4: t = ai | bi;
            3'd5: t = ai ^ bi;
            default: begin t = 0; defd = 0; end
        endcase
        t = t & mask;
        r = t[15:0];
        ones = 0;
        for (int k = 0; k < 8; k++) ones += (t >> k) & 1;
        st = '0;
        st[0]  = c;
        st[2]  = defd && (ones % 2 == 0);
        st[4]  = af;
        st[6]  = defd && (t == 0);
        st[7]  = defd && (((t >> top) & 1) == 1);
        st[10:8] = ctl;
        st[11] = ov;
    endtask

    function automatic string res_tag(input logic [2:0] op, input logic w);
        if (!w && op < 3'd6) return "R9/res";
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4, 3'd5: return "R4";
            default: return "R10";
        endcase
    endfunction

    function automatic string st_tag(input logic [2:0] op, input logic [15:0] diff);
        if (op > 3'd5) return "R10";
        if (diff[0]) return (op == 3'd0) ? "R1" : (op == 3'd1) ? "R2" : (op == 3'd2) ? "R3" : "R4";
        if (diff[2]) return "R6";
        if (diff[4]) return (op > 3'd2) ? "R4" : "R7";
        if (diff[6] || diff[7]) return "R5";
        if (diff[11]) return (op > 3'd2) ? "R4" : "R8";
        return "R11";
    endfunction

    // Drive one vector, let it settle, compare result and status.
    task automatic run_vec(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                           input logic w, input logic [2:0] ctl);
        logic [15:0] er, es;
        a_in = a; b_in = b; op_in = op; wide_in = w; ctrl_in = ctl;
        #1;
        model(a, b, op, w, ctl, er, es);
        checks += 2;
        if (res_out !== er) begin
            failures++;
            $display("FAIL %s result a=%h b=%h op=%0d w=%0d: actual %h expected %h",
                     res_tag(op, w), a, b, op, w, res_out, er);
        end
        if (stat_out !== es) begin
            failures++;
            $display("FAIL %s status a=%h b=%h op=%0d w=%0d: actual %h expected %h",
                     st_tag(op, stat_out ^ es), a, b, op, w, stat_out, es);
        end
    endtask

    logic [15:0] corners [16];
    logic [15:0] lfsr_a, lfsr_b;

    initial begin
        corners = '{16'h0000, 16'h0001, 16'h000F, 16'h0010, 16'h007F, 16'h0080,
                    16'h00FF, 16'h0100, 16'h0F0F, 16'h7FFE, 16'h7FFF, 16'h8000,
                    16'h8001, 16'hFF7F, 16'hFF80, 16'hFFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Idle state: add of zeros gives zero result, Z and P set (R5, R6).
        run_vec(16'h0000, 16'h0000, 3'd0, 1'b0, 3'b000);

        // Exhaustive byte mode for all defined codes (R1-R9 at width 8).
        for (int op = 0; op < 6; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    // upper bytes set to prove R9 masking
                    run_vec({8'hA5, a[7:0]}, {8'h5A, b[7:0]}, op[2:0], 1'b0, 3'b000);
                end
            end
        end

        // Word-mode boundary grid (R1, R2, R3, R5, R7, R8 at width 16).
        for (int op = 0; op < 6; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    run_vec(corners[i], corners[j], op[2:0], 1'b1, 3'b000);
                end
            end
        end

        // Word-mode pseudo-random pairs; R2 with random upper B byte ignored.
        lfsr_a = 16'hACE1; lfsr_b = 16'h1D0B;
        for (int n = 0; n < 2000; n++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
            for (int op = 0; op < 6; op++) begin
                run_vec(lfsr_a, lfsr_b, op[2:0], 1'b1, 3'b000);
            end
        end

        // Undefined codes: zero result, flags clear, ctrl still passes (R10, R11).
        for (int op = 6; op < 8; op++) begin
            for (int i = 0; i < 16; i++) begin
                run_vec(corners[i], corners[15 - i], op[2:0], i[0], i[2:0]);
            end
        end

        // Control bits through every code and width (R11).
        for (int ctl = 0; ctl < 8; ctl++) begin
            for (int op = 0; op < 8; op++) begin
                run_vec(16'h8000, 16'h8000, op[2:0], ctl[0], ctl[2:0]);
                run_vec(16'h00FF, 16'h0001, op[2:0], ~ctl[0], ctl[2:0]);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule